// File: doc/BRIEF.md
# Video Capture FIFO Flush Sequencer

This block runs a software-requested flush of the buffering in a video capture path. Software writes a 1 to the flush bit of a small control register. The sequencer then stops taking pixels, pulses clear strobes to the input-side and output-side FIFOs, and waits until every memory request already in flight has completed. The flush bit then drops back to 0 by itself. Capture stays parked until the chosen timing boundary arrives: the start of a line, the start of a field or the start of a frame. Only then does pixel flow resume.

The same register holds the sync settings that decide what counts as a boundary. These are the separate-sync mode bit, the HSYNC and VSYNC blanking polarities and the boundary selector. It also holds a task-signal inversion bit and a sticky flag. The flag records that pixels were thrown away while capture was parked.

Pixels pass through the block on a valid/ready stream. When the block is idle, the stream is a straight wire: `pix_out_valid` follows `pix_in_valid`, `pix_in_ready` follows `pix_out_ready`, and the data is unchanged. A source must hold valid and data steady until ready is seen. While the block is parked, it holds `pix_in_ready` high so that no source ever stalls. Every offered pixel is consumed and dropped, and `pix_out_valid` stays low.

Top module: `vcap_flush_seq`

Control register (read back on `reg_rdata` at all times; all bits reset to 0):
- bit 0: flush. Write 1 to start; reads 1 while a flush is running.
- bit 1: separate-sync mode.
- bit 2: HSYNC polarity.
- bit 3: VSYNC polarity.
- bit 4: task invert.
- bits 6:5: boundary select.
- bit 7: discard flag. Read-only; write 1 to clear.

## Requirements
- R1: Writing 1 to bit 0 while idle starts a flush. From the cycle after that write, bit 0 reads 1, and it returns to 0 on its own one cycle after the outstanding-request count is seen at zero in the drain step.
- R2: From the first cycle of a flush until capture resumes, `intake_halt` is 1, `pix_out_valid` is 0 and `pix_in_ready` is 1.
- R3: `in_fifo_clr` and `out_fifo_clr` are both 1 for exactly one cycle, the second cycle of the flush, and are 0 at all other times.
- R4: The outstanding count rises by one on `mem_req_issue`, falls by one on `mem_req_done`, and is unchanged when both are high together. Bit 0 stays 1 for as long as the count is non-zero.
- R5: After bit 0 clears, capture stays halted until the selected boundary. Bits 6:5 = 0 selects start of line, 1 selects start of field, and 2 or 3 selects start of frame. Start of frame is a start of field while `field_first` is 1. Capture resumes the cycle after the boundary is seen.
- R6: Start of line (field) is the cycle in which HSYNC (VSYNC), once normalized, leaves its active level. With bit 1 = 1, a polarity bit of 1 means the pin is high during blanking and 0 means it is low. With bit 1 = 0, both pins are taken as high during blanking and the polarity bits are ignored.
- R7: `task_out` equals `task_in` inverted when bit 4 is 1, and equals `task_in` otherwise.
- R8: Writing 1 to bit 0 during a flush has no effect on the sequence, and writing 0 never aborts it.
- R9: A pixel offered while capture is halted is dropped and sets bit 7 on the next cycle. Writing 1 to bit 7 clears it.
- R10: When idle, the stream passes straight through, as set out above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| mem_req_issue | input | 1 | A memory request was issued this cycle |
| mem_req_done | input | 1 | A memory request completed this cycle |
| hsync_in | input | 1 | Horizontal sync pin |
| vsync_in | input | 1 | Vertical sync pin |
| field_first | input | 1 | High while the first field of a frame is current |
| task_in | input | 1 | Raw task input |
| task_out | output | 1 | Task after optional inversion |
| pix_in_valid | input | 1 | Input pixel valid |
| pix_in_ready | output | 1 | Input pixel ready |
| pix_in_data | input | DATA_W | Input pixel data |
| pix_out_valid | output | 1 | Output pixel valid |
| pix_out_ready | input | 1 | Output pixel ready |
| pix_out_data | output | DATA_W | Output pixel data |
| intake_halt | output | 1 | Capture halted |
| in_fifo_clr | output | 1 | Clear input FIFO pointers and count |
| out_fifo_clr | output | 1 | Clear output FIFO pointers and count |

## Verification
The bench builds the block with DATA_W = 8 and CNT_W = 4. With that count width, several requests can be in flight at once, so the drain step can be held over many cycles. It also lets an issue and a completion land in the same cycle. The narrow data path keeps the pass-through patterns readable. Every boundary selector is exercised, and both sync modes are run with each polarity setting that matters.

// File: rtl/vcap_flush_pkg.sv
package vcap_flush_pkg;
  localparam int REG_W       = 8;
  localparam int BIT_FLUSH   = 0;
  localparam int BIT_SEP     = 1;
  localparam int BIT_HPOL    = 2;
  localparam int BIT_VPOL    = 3;
  localparam int BIT_TINV    = 4;
  localparam int BIT_ARM_LO  = 5;
  localparam int BIT_DISCARD = 7;
  localparam int N_SYNC      = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HALT, ST_CLEAR, ST_DRAIN, ST_ARM
  } seq_state_t;

  typedef enum logic [1:0] {
    ARM_LINE = 2'd0, ARM_FIELD = 2'd1, ARM_FRAME = 2'd2, ARM_FRAME_B = 2'd3
  } arm_sel_t;
endpackage

// File: rtl/vcap_sync_detect.sv
module vcap_sync_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic sep_mode,
  input  logic pol,
  output logic blank_end
);
  logic active;
  logic active_q;

  // separate mode: pol=1 -> high in blanking, pol=0 -> low in blanking
  assign active = sep_mode ? (pol ? pin : ~pin) : pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active;
  end

  assign blank_end = active_q & ~active;
endmodule

// File: rtl/vcap_req_tracker.sv
module vcap_req_tracker #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             done,
  output logic             none_open,
  output logic [CNT_W-1:0] open_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_cnt <= '0;
    else if (issue && !done && open_cnt != CNT_MAX) open_cnt <= open_cnt + 1'b1;
    else if (done && !issue && open_cnt != '0)      open_cnt <= open_cnt - 1'b1;
  end

  assign none_open = (open_cnt == '0);

  AST_CNT_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !done && open_cnt != CNT_MAX) |=> (open_cnt == $past(open_cnt) + 1'b1)); // R4
  AST_CNT_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && done) |=> $stable(open_cnt)); // R4
endmodule

// File: rtl/vcap_flush_fsm.sv
module vcap_flush_fsm
  import vcap_flush_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic none_open,
  input  logic arm_event,
  output logic flush_busy,
  output logic halted,
  output logic fifo_clr
);
  seq_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (start) state_nx = ST_HALT;
      ST_HALT:  state_nx = ST_CLEAR;
      ST_CLEAR: state_nx = ST_DRAIN;
      ST_DRAIN: if (none_open) state_nx = ST_ARM;
      ST_ARM:   if (arm_event) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign flush_busy = (state == ST_HALT) || (state == ST_CLEAR) || (state == ST_DRAIN);
  assign halted     = (state != ST_IDLE);
  assign fifo_clr   = (state == ST_CLEAR);

  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> !fifo_clr); // R3
  AST_DRAIN_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRAIN && !none_open) |=> flush_busy); // R4
  AST_ARM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARM && !arm_event) |=> halted); // R5
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRAIN && !none_open && start) |=> (state == ST_DRAIN)); // R8
endmodule

// File: rtl/vcap_flush_seq.sv
module vcap_flush_seq
  import vcap_flush_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              mem_req_issue,
  input  logic              mem_req_done,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic              field_first,
  input  logic              task_in,
  output logic              task_out,
  input  logic              pix_in_valid,
  output logic              pix_in_ready,
  input  logic [DATA_W-1:0] pix_in_data,
  output logic              pix_out_valid,
  input  logic              pix_out_ready,
  output logic [DATA_W-1:0] pix_out_data,
  output logic              intake_halt,
  output logic              in_fifo_clr,
  output logic              out_fifo_clr
);
  logic       sep_mode, hs_pol, vs_pol, task_inv, discard;
  arm_sel_t   arm_sel;
  logic       flush_busy, halted, fifo_clr, none_open, arm_event;
  logic [CNT_W-1:0] open_cnt;
  logic [N_SYNC-1:0] sync_pin, sync_pol, blank_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sep_mode <= 1'b0;
      hs_pol   <= 1'b0;
      vs_pol   <= 1'b0;
      task_inv <= 1'b0;
      arm_sel  <= ARM_LINE;
    end else if (reg_wr) begin
      sep_mode <= reg_wdata[BIT_SEP];
      hs_pol   <= reg_wdata[BIT_HPOL];
      vs_pol   <= reg_wdata[BIT_VPOL];
      task_inv <= reg_wdata[BIT_TINV];
      arm_sel  <= arm_sel_t'(reg_wdata[BIT_ARM_LO +: 2]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                discard <= 1'b0;
    else if (halted && pix_in_valid)           discard <= 1'b1;
    else if (reg_wr && reg_wdata[BIT_DISCARD]) discard <= 1'b0;
  end

  assign sync_pin = {vsync_in, hsync_in};
  assign sync_pol = {vs_pol, hs_pol};

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    vcap_sync_detect u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin       (sync_pin[g]),
      .sep_mode  (sep_mode),
      .pol       (sync_pol[g]),
      .blank_end (blank_end[g])
    );
  end

  always_comb begin
    unique case (arm_sel)
      ARM_LINE:  arm_event = blank_end[0];
      ARM_FIELD: arm_event = blank_end[1];
      default:   arm_event = blank_end[1] & field_first;
    endcase
  end

  vcap_req_tracker #(.CNT_W(CNT_W)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (mem_req_issue),
    .done      (mem_req_done),
    .none_open (none_open),
    .open_cnt  (open_cnt)
  );

  vcap_flush_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (reg_wr && reg_wdata[BIT_FLUSH]),
    .none_open  (none_open),
    .arm_event  (arm_event),
    .flush_busy (flush_busy),
    .halted     (halted),
    .fifo_clr   (fifo_clr)
  );

  assign reg_rdata = {discard, logic'(arm_sel[1]), logic'(arm_sel[0]),
                      task_inv, vs_pol, hs_pol, sep_mode, flush_busy};

  assign task_out      = task_in ^ task_inv;
  assign pix_out_valid = pix_in_valid & ~halted;
  assign pix_in_ready  = halted | pix_out_ready;
  assign pix_out_data  = pix_in_data;
  assign intake_halt   = halted;
  assign in_fifo_clr   = fifo_clr;
  assign out_fifo_clr  = fifo_clr;

  AST_NO_OUT_WHILE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    intake_halt |-> (!pix_out_valid && pix_in_ready)); // R2
  AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (intake_halt && pix_in_valid) |=> reg_rdata[BIT_DISCARD]); // R9
  AST_CLR_INSIDE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    in_fifo_clr |-> (intake_halt && reg_rdata[BIT_FLUSH])); // R3
endmodule

// File: tb/test_vcap_flush_seq.sv
module test_vcap_flush_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic mem_req_issue = 1'b0, mem_req_done = 1'b0;
  logic hsync_in = 1'b0, vsync_in = 1'b0, field_first = 1'b0;
  logic task_in = 1'b0, task_out;
  logic pix_in_valid = 1'b0, pix_in_ready, pix_out_valid, pix_out_ready = 1'b0;
  logic [DW-1:0] pix_in_data = '0, pix_out_data;
  logic intake_halt, in_fifo_clr, out_fifo_clr;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcap_flush_seq #(.DATA_W(DW), .CNT_W(4)) i_vcap_flush_seq (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // fields: arm[6:5] tinv[4] vpol[3] hpol[2] sep[1] flush[0]; bit7 clears flag
  function automatic logic [7:0] cfg(int arm, bit tinv, bit vpol, bit hpol, bit sep,
                                     bit flush, bit clr);
    return {clr, 2'(arm), tinv, vpol, hpol, sep, flush};
  endfunction

  task automatic wr(logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d; tick(); reg_wr = 1'b0;
  endtask

  // runs write, HALT, CLEAR, DRAIN with no requests open; ends in ARM
  task automatic flush_to_arm(logic [7:0] c);
    wr(c);
    tick(); tick(); tick();
  endtask

  task automatic t_reset();
    chk("R1 reset rdata", reg_rdata, 8'h00);
    chk("R2 reset halt", intake_halt, 1'b0);
    chk("R3 reset clr", {in_fifo_clr, out_fifo_clr}, 2'b00);
  endtask

  task automatic t_pass();
    pix_in_valid = 1'b1; pix_in_data = 8'hA5; pix_out_ready = 1'b0; #1;
    chk("R10 valid", pix_out_valid, 1'b1);
    chk("R10 ready low", pix_in_ready, 1'b0);
    chk("R10 data", pix_out_data, 8'hA5);
    pix_out_ready = 1'b1; pix_in_data = 8'h3C; #1;
    chk("R10 ready high", pix_in_ready, 1'b1);
    chk("R10 data2", pix_out_data, 8'h3C);
    pix_in_valid = 1'b0; #1;
    chk("R10 idle valid", pix_out_valid, 1'b0);
  endtask

  task automatic t_task_pol();
    task_in = 1'b1; #1;
    chk("R7 plain", task_out, 1'b1);
    wr(cfg(0, 1, 0, 0, 0, 0, 0));
    chk("R7 inverted", task_out, 1'b0);
    task_in = 1'b0; #1;
    chk("R7 inverted0", task_out, 1'b1);
    wr(cfg(0, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_basic_line();
    pix_out_ready = 1'b0;
    wr(cfg(0, 0, 0, 0, 0, 1, 0));
    chk("R1 busy after write", reg_rdata[0], 1'b1);
    chk("R2 halt", intake_halt, 1'b1);
    chk("R3 no clr in first cycle", in_fifo_clr, 1'b0);
    pix_in_valid = 1'b1; pix_in_data = 8'h11; #1;
    chk("R2 out valid low", pix_out_valid, 1'b0);
    chk("R2 in ready high", pix_in_ready, 1'b1);
    tick(); pix_in_valid = 1'b0;
    chk("R3 clr pulse", {in_fifo_clr, out_fifo_clr}, 2'b11);
    chk("R9 flag set", reg_rdata[7], 1'b1);
    tick();
    chk("R3 clr gone", {in_fifo_clr, out_fifo_clr}, 2'b00);
    chk("R1 busy in drain", reg_rdata[0], 1'b1);
    tick();
    chk("R1 self clear", reg_rdata[0], 1'b0);
    chk("R5 still halted", intake_halt, 1'b1);
    tick(); tick();
    chk("R5 no event yet", intake_halt, 1'b1);
    hsync_in = 1'b1; tick();
    hsync_in = 1'b0; #1;
    chk("R6 halted on event cycle", intake_halt, 1'b1);
    tick();
    chk("R5 line release", intake_halt, 1'b0);
    wr(cfg(0, 0, 0, 0, 0, 0, 1));
    chk("R9 flag cleared", reg_rdata[7], 1'b0);
  endtask

  task automatic t_drain();
    for (int i = 0; i < 3; i++) begin
      mem_req_issue = 1'b1; tick();
    end
    mem_req_issue = 1'b0;
    wr(cfg(0, 0, 0, 0, 0, 1, 0));
    tick(); tick();
    tick(); tick();
    chk("R4 held by open requests", reg_rdata[0], 1'b1);
    wr(cfg(0, 0, 0, 0, 0, 1, 0));
    chk("R8 rewrite no new clr", in_fifo_clr, 1'b0);
    chk("R8 rewrite still busy", reg_rdata[0], 1'b1);
    wr(cfg(0, 0, 0, 0, 0, 0, 0));
    chk("R8 write0 no abort", reg_rdata[0], 1'b1);
    mem_req_done = 1'b1; tick(); tick();
    mem_req_issue = 1'b1; tick();
    mem_req_issue = 1'b0;
    chk("R4 both same cycle", reg_rdata[0], 1'b1);
    tick();
    mem_req_done = 1'b0;
    chk("R4 count just reached zero", reg_rdata[0], 1'b1);
    tick();
    chk("R1 clears after drain", reg_rdata[0], 1'b0);
    chk("R5 halted after drain", intake_halt, 1'b1);
    hsync_in = 1'b1; tick(); hsync_in = 1'b0; tick();
    chk("R5 release after drain", intake_halt, 1'b0);
  endtask

  task automatic t_sep_polarity();
    hsync_in = 1'b1; vsync_in = 1'b0;
    flush_to_arm(cfg(1, 0, 1, 0, 1, 1, 0));
    chk("R5 field arm", intake_halt, 1'b1);
    hsync_in = 1'b0; tick(); hsync_in = 1'b1; tick();
    chk("R5 line edge ignored in field mode", intake_halt, 1'b1);
    vsync_in = 1'b1; tick(); vsync_in = 1'b0; tick();
    chk("R6 vsync active high release", intake_halt, 1'b0);
    flush_to_arm(cfg(0, 0, 1, 0, 1, 1, 0));
    hsync_in = 1'b0; tick();
    chk("R6 active low still blank", intake_halt, 1'b1);
    hsync_in = 1'b1; tick();
    chk("R6 hsync active low release", intake_halt, 1'b0);
    wr(cfg(0, 0, 0, 0, 0, 0, 0));
    hsync_in = 1'b0; tick();
    flush_to_arm(cfg(0, 0, 0, 0, 0, 1, 0));
    hsync_in = 1'b1; tick();
    chk("R6 embedded ignores pol", intake_halt, 1'b1);
    hsync_in = 1'b0; tick();
    chk("R6 embedded release", intake_halt, 1'b0);
  endtask

  task automatic t_frame();
    flush_to_arm(cfg(2, 0, 0, 0, 0, 1, 0));
    field_first = 1'b0;
    vsync_in = 1'b1; tick(); vsync_in = 1'b0; tick();
    chk("R5 second field no release", intake_halt, 1'b1);
    hsync_in = 1'b1; tick(); hsync_in = 1'b0; tick();
    chk("R5 line no release in frame", intake_halt, 1'b1);
    field_first = 1'b1;
    vsync_in = 1'b1; tick(); vsync_in = 1'b0; tick();
    chk("R5 frame release", intake_halt, 1'b0);
    field_first = 1'b0;
    flush_to_arm(cfg(3, 0, 0, 0, 0, 1, 0));
    field_first = 1'b1;
    vsync_in = 1'b1; tick(); vsync_in = 1'b0; tick();
    chk("R5 code 3 frame release", intake_halt, 1'b0);
    field_first = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_pass();
    t_task_pol();
    t_basic_line();
    t_drain();
    t_sep_polarity();
    t_frame();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule